// File: doc/BRIEF.md
# Level Interrupt Storm Throttle

This block watches the end-of-interrupt path of a level-triggered interrupt router. Each end-of-interrupt event names one pin. If that pin is level-mode, unmasked and its request is still asserted, the router would normally redeliver it at once. The block allows that immediate redelivery and keeps a per-pin count of how many happened back to back.

When a pin's count reaches a threshold, the block holds back that redelivery and clears the count. Instead it arms a single delay timer. When the timer runs out, the block walks every pin once, lowest index first, spending one cycle on each pin. It issues a deferred service request for each pin that is level-mode, has its request set and has its remote-pending bit clear. The delay is a tenth of a second divided by ten (10 ms), expressed as `CLK_HZ/100` clock cycles. This lets a guest that mishandles a level interrupt still make slow progress instead of livelocking.

Top module: `storm_throttle`

## Requirements
- R1: After reset, `redeliver_valid` and `defer_valid` are low, every pin count is zero and no deferral is pending.
- R2: An event on an in-range pin that has `level_mode`=1, `mask_bits`=0 and `req_bits`=1 raises the pin's count by one. When the new count is below `THRESH`, `redeliver_valid` is high with `redeliver_pin` equal to that pin in the cycle after the event edge.
- R3: The `THRESH`-th such event in a row on a pin gives no redelivery, returns that pin's count to zero and arms the deferral.
- R4: An event on a level-mode pin whose mask bit is 1 or whose request bit is 0 gives no redelivery and returns that pin's count to zero.
- R5: An event on a pin with `level_mode`=0 (edge mode) gives no redelivery and leaves the pin's count unchanged.
- R6: If the deferral is armed at edge A, pin k is examined at edge A+DLY+1+k, where DLY=`CLK_HZ/100`. Its request, if any, shows on `defer_valid`/`defer_pin` after that edge. Pins are examined one per cycle in ascending order.
- R7: During the walk, a request is issued only for pins with `level_mode`=1, `req_bits`=1 and `remote_pend`=0.
- R8: A threshold hit while a deferral is pending (timer running or walk in progress) neither restarts the timer nor adds a second walk.
- R9: Asserting reset cancels a pending deferral and clears every pin count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_valid | input | 1 | End-of-interrupt event this cycle |
| eoi_pin | input | PW | Pin named by the event |
| req_bits | input | NPINS | Request bit of each pin |
| mask_bits | input | NPINS | Mask bit of each pin (1 = masked) |
| level_mode | input | NPINS | Trigger mode of each pin (1 = level, 0 = edge) |
| remote_pend | input | NPINS | Remote-pending bit of each pin |
| redeliver_valid | output | 1 | Immediate redelivery request |
| redeliver_pin | output | PW | Pin to redeliver |
| defer_valid | output | 1 | Deferred service request |
| defer_pin | output | PW | Pin for the deferred service |

## Verification
An immediate redelivery is due in the cycle right after the edge that accepts the event. The bench drives each event half a cycle before that edge and reads `redeliver_valid` at the following falling edge.

A deferred request for pin k is due DLY+1+k edges after the accepting edge. A falling-edge monitor records the rising-edge count of every deferred request. Each deferral scenario then compares those recorded counts and pins with the eligibility mask the bench expects.

The bench uses a small threshold and a short delay. This lets counter wrap, timer no-restart and reset cancellation all be exercised exactly.

// File: rtl/storm_throttle.sv
module storm_throttle #(
  parameter int NPINS  = 8,
  parameter int THRESH = 10000,
  parameter int CLK_HZ = 50_000_000,
  localparam int PW  = $clog2(NPINS),
  localparam int CW  = $clog2(THRESH + 1),
  localparam int DLY = CLK_HZ / 100,
  localparam int TW  = $clog2(DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoi_valid,
  input  logic [PW-1:0]    eoi_pin,
  input  logic [NPINS-1:0] req_bits,
  input  logic [NPINS-1:0] mask_bits,
  input  logic [NPINS-1:0] level_mode,
  input  logic [NPINS-1:0] remote_pend,
  output logic             redeliver_valid,
  output logic [PW-1:0]    redeliver_pin,
  output logic             defer_valid,
  output logic [PW-1:0]    defer_pin
);

  logic [CW-1:0] cnt [NPINS];
  logic          pend, scan;
  logic [TW-1:0] tmr;
  logic [PW-1:0] idx;

  wire in_rng = {1'b0, eoi_pin} < (PW+1)'(NPINS);
  wire live   = eoi_valid && in_rng && level_mode[eoi_pin];
  wire fire   = live && req_bits[eoi_pin] && !mask_bits[eoi_pin];
  wire at_lim = fire && (cnt[eoi_pin] == CW'(THRESH - 1));
  wire elig   = level_mode[idx] && req_bits[idx] && !remote_pend[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) cnt[i] <= '0;
      redeliver_valid <= 1'b0;
      redeliver_pin   <= '0;
      defer_valid     <= 1'b0;
      defer_pin       <= '0;
      pend <= 1'b0;
      scan <= 1'b0;
      tmr  <= '0;
      idx  <= '0;
    end else begin
      redeliver_valid <= fire && !at_lim;
      redeliver_pin   <= eoi_pin;
      defer_valid     <= 1'b0;
      for (int i = 0; i < NPINS; i++)
        if (live && eoi_pin == PW'(i))
          cnt[i] <= (fire && !at_lim) ? cnt[i] + CW'(1) : '0;
      if (!pend) begin
        if (at_lim) begin
          pend <= 1'b1;
          tmr  <= TW'(DLY - 1);
        end
      end else if (!scan) begin
        if (tmr == '0) begin
          scan <= 1'b1;
          idx  <= '0;
        end else begin
          tmr <= tmr - TW'(1);
        end
      end else begin
        defer_valid <= elig;
        defer_pin   <= idx;
        if (idx == PW'(NPINS - 1)) begin
          scan <= 1'b0;
          pend <= 1'b0;
        end else begin
          idx <= idx + PW'(1);
        end
      end
    end
  end

  a_r2_redeliver_cause: assert property (@(posedge clk) disable iff (!rst_n)
    redeliver_valid |-> $past(eoi_valid && level_mode[eoi_pin] &&
                              req_bits[eoi_pin] && !mask_bits[eoi_pin]));

  a_r2_redeliver_pin: assert property (@(posedge clk) disable iff (!rst_n)
    redeliver_valid |-> redeliver_pin == $past(eoi_pin));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    a_r3_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] < CW'(THRESH));
  end

  a_r6_defer_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    defer_valid |-> $past(scan) && $past(pend));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    defer_valid && $past(defer_valid) |-> defer_pin > $past(defer_pin));

endmodule

// File: tb/test_storm_throttle.sv
module test_storm_throttle;
  localparam int N = 8;
  localparam int TH = 4;
  localparam int HZ = 2000;
  localparam int DLY = HZ / 100;

  logic clk = 0, rst_n = 0;
  logic eoi_v = 0;
  logic [2:0] eoi_p = '0;
  logic [N-1:0] req = '0, msk = '0, lvl = '0, rem = '0;
  logic rd_v, df_v;
  logic [2:0] rd_p, df_p;

  storm_throttle #(.NPINS(N), .THRESH(TH), .CLK_HZ(HZ)) i_storm_throttle (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_v), .eoi_pin(eoi_p),
    .req_bits(req), .mask_bits(msk), .level_mode(lvl), .remote_pend(rem),
    .redeliver_valid(rd_v), .redeliver_pin(rd_p),
    .defer_valid(df_v), .defer_pin(df_p));

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, dn = 0;
  int dpin [64];
  int dcyc [64];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && df_v && dn < 64) begin
    dpin[dn] = int'(df_p); dcyc[dn] = cyc; dn++;
  end

  task automatic finish_tb;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog: actual cyc=%0d expected below 100000", cyc);
    finish_tb();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_eoi(input int p, input bit exp_rd, input string tag, output int acc);
    @(negedge clk); eoi_v = 1; eoi_p = p[2:0];
    @(posedge clk); @(negedge clk); eoi_v = 0; acc = cyc;
    chk(rd_v == exp_rd, tag, int'(rd_v), int'(exp_rd));
    if (exp_rd) chk(int'(rd_p) == p, tag, int'(rd_p), p);
  endtask

  task automatic check_defer(input int a, input logic [N-1:0] elig, input string tag);
    int k;
    while (cyc <= a + DLY + N + 2) @(negedge clk);
    k = 0;
    for (int p = 0; p < N; p++) if (elig[p]) begin
      if (k < dn) begin
        chk(dpin[k] == p, {tag, " pin"}, dpin[k], p);
        chk(dcyc[k] == a + DLY + 1 + p, {tag, " cycle"}, dcyc[k], a + DLY + 1 + p);
      end
      k++;
    end
    chk(dn == k, {tag, " count"}, dn, k);
    dn = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rd_v == 0, "R1 redeliver after reset", int'(rd_v), 0);
    chk(df_v == 0, "R1 defer after reset", int'(df_v), 0);
  endtask

  task automatic t_below_hit;
    int a;
    req = 8'b0110_0110; rem = 8'b0010_0000; lvl = 8'hBF; msk = '0; dn = 0;
    for (int i = 0; i < TH - 1; i++) do_eoi(2, 1, "R2 below threshold", a);
    do_eoi(2, 0, "R3 threshold withholds", a);
    check_defer(a, lvl & req & ~rem, "R6 R7 walk");
    for (int i = 0; i < TH - 1; i++) do_eoi(2, 1, "R3 count cleared", a);
  endtask

  task automatic t_mask_req;
    int a;
    req = 8'hFF; rem = '0; lvl = 8'hBF; msk = '0; dn = 0;
    for (int i = 0; i < TH - 1; i++) do_eoi(3, 1, "R2 pin3", a);
    msk[3] = 1; do_eoi(3, 0, "R4 masked", a); msk[3] = 0;
    for (int i = 0; i < TH - 1; i++) do_eoi(3, 1, "R4 after mask", a);
    req[3] = 0; do_eoi(3, 0, "R4 request clear", a); req[3] = 1;
    for (int i = 0; i < TH - 1; i++) do_eoi(3, 1, "R4 after req", a);
    do_eoi(3, 0, "R3 hit pin3", a);
    check_defer(a, lvl & req & ~rem, "R7 walk all level");
  endtask

  task automatic t_edge;
    int a;
    req = 8'hFF; rem = '0; lvl = 8'hFF; msk = '0; dn = 0;
    for (int i = 0; i < 2; i++) do_eoi(6, 1, "R2 pin6", a);
    lvl[6] = 0; do_eoi(6, 0, "R5 edge no redeliver", a); lvl[6] = 1;
    do_eoi(6, 1, "R5 count kept", a);
    do_eoi(6, 0, "R5 count kept hit", a);
    check_defer(a, lvl & req & ~rem, "R5 walk");
  endtask

  task automatic t_no_restart;
    int a, b;
    req = 8'h0F; rem = '0; lvl = 8'hBF; msk = '0; dn = 0;
    for (int i = 0; i < TH - 1; i++) do_eoi(0, 1, "R8 prime0", b);
    for (int i = 0; i < TH - 1; i++) do_eoi(1, 1, "R8 prime1", b);
    do_eoi(0, 0, "R8 first hit", a);
    do_eoi(1, 0, "R8 second hit", b);
    check_defer(a, lvl & req & ~rem, "R8 single walk");
  endtask

  task automatic t_reset_cancel;
    int a;
    req = 8'hFF; rem = '0; lvl = 8'hBF; msk = '0;
    for (int i = 0; i < TH - 1; i++) do_eoi(4, 1, "R9 prime4", a);
    do_eoi(4, 0, "R9 hit", a);
    repeat (3) @(negedge clk);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; dn = 0;
    repeat (DLY + N + 5) @(negedge clk);
    chk(dn == 0, "R9 deferral cancelled", dn, 0);
    for (int i = 0; i < TH - 1; i++) do_eoi(2, 1, "R9 counts cleared", a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_below_hit();
    t_mask_req();
    t_edge();
    t_no_restart();
    t_reset_cancel();
    repeat (4) @(negedge clk);
    finish_tb();
  end
endmodule